// File: doc/BRIEF.md
# Destination allocation unit for an on-chip packet network

This unit sits next to the network interface of a source processing element and decides where that element sends its next data. Candidate destinations send it short control reports. Each report carries the sender's 4-bit ID, its current 8-bit utilization and its own 4-bit hop distance from the source. Because the distance travels inside the report, the source keeps no per-destination lookup table.

Time is divided into allocation intervals of a configurable number of cycles. The first report of an interval opens a collection window of a configurable number of cycles. Reports that arrive in the window are queued in a small FIFO. When the window closes, the queued reports are drained through a running comparator. A report's cost is four times its utilization plus its hop count. The cheapest report wins, and among equal costs the lower ID wins. The winner is published with a one-cycle strobe.

An element that stays silent during the window never enters the comparison, so a failed element is routed around automatically. If no report arrives in a whole interval, the previous destination is kept and a one-cycle flag says so.

Top module: `dest_picker`

## Requirements
- R1: While reset is held and on the first cycle after it, destValid, noCandidate and fifoOverflow are 0 and destId is 0.
- R2: The published destId is the ID of the kept report with the smallest cost, where cost = pktUtil*4 + pktHops.
- R3: When several kept reports share the smallest cost, the one with the lowest pktId is published.
- R4: The first report of an interval, accepted on clock edge e, opens a window of edges e to e+W-1 (W = loaded window length, at least 1). Reports on later edges of the same interval are discarded and never affect destId.
- R5: With k reports kept in the window, destValid is high for exactly one cycle, seen right after edge e+W+k, and destId takes the new value on that same edge.
- R6: If an interval ends with no report received, noCandidate is high for one cycle after the interval's last edge, destValid stays 0 and destId keeps its previous value.
- R7: The FIFO holds FIFO_DEPTH reports (default 8). A report that arrives inside the window while the FIFO is full is dropped, and fifoOverflow is high for one cycle per dropped report. The first FIFO_DEPTH reports are the ones kept.
- R8: At most one decision is made per interval. After a decision, further reports in that interval produce no strobe. The next interval then opens a fresh window.
- R9: A cfgLoad pulse loads cfgInterval as T and cfgWindow as W. It restarts the interval count, abandons any open window or drain without a decision, and produces no strobe on the following cycle. An interval ends on the T-th edge after the load or after the previous interval end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Load interval and window lengths and restart the interval |
| cfgInterval | input | CNT_W (16) | Interval length T in cycles |
| cfgWindow | input | CNT_W (16) | Window length W in cycles |
| pktValid | input | 1 | A control report is present this cycle |
| pktId | input | 4 | ID of the reporting element |
| pktUtil | input | 8 | Utilization of the reporting element |
| pktHops | input | 4 | Hop distance of the reporting element |
| destValid | output | 1 | One-cycle strobe: a new destination was chosen |
| destId | output | 4 | Current destination ID |
| noCandidate | output | 1 | One-cycle flag: the interval ended with no report |
| fifoOverflow | output | 1 | One-cycle flag: an in-window report was dropped because the FIFO was full |

## Verification
Several properties are checked on every cycle. The decision and no-candidate strobes last a single cycle and never coincide. destId changes only on a decision. The queue never exceeds its depth and is never written and drained in the same cycle. The running best cost never rises while reports are drained. A configuration load silences both strobes on the following cycle.

The remaining behaviours can only be shown by the bench's scenarios. These are which report wins under many utilization and hop patterns, tie breaking by ID, the exact edge on which the decision lands for different window lengths and report counts, the rejection of late, excess or post-decision reports, and the keep-previous behaviour of an empty interval.

// File: rtl/dest_picker_pkg.sv
package dest_picker_pkg;

  localparam int ID_W       = 4;
  localparam int UTIL_W     = 8;
  localparam int HOP_W      = 4;
  localparam int UTIL_SHIFT = 2;
  localparam int COST_W     = UTIL_W + UTIL_SHIFT + 1;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [UTIL_W-1:0] util;
    logic [HOP_W-1:0]  hops;
  } report_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
    logic decide;
  } strobe_t;

  typedef enum logic [1:0] {
    S_WAIT   = 2'd0,
    S_WINDOW = 2'd1,
    S_DRAIN  = 2'd2,
    S_DONE   = 2'd3
  } phase_t;

  function automatic logic [COST_W-1:0] report_cost(report_t r);
    return (COST_W'(r.util) << UTIL_SHIFT) + COST_W'(r.hops);
  endfunction

endpackage

// File: rtl/dest_picker_ctrl.sv
module dest_picker_ctrl
  import dest_picker_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEF_T = 256,
  parameter int DEF_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] cfgInterval,
  input  logic [CNT_W-1:0] cfgWindow,
  input  logic             pktValid,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  output strobe_t          stb,
  output logic             destValid,
  output logic             noCandidate,
  output logic             fifoOverflow
);

  logic [CNT_W-1:0] cfgT;
  logic [CNT_W-1:0] cfgW;
  logic [CNT_W-1:0] intCnt;
  logic [CNT_W-1:0] winCnt;
  logic [CNT_W:0]   winNext;
  phase_t           phase;
  logic             intervalEnd;
  logic             accept;

  always_comb begin
    intervalEnd = (intCnt == cfgT - CNT_W'(1));
    winNext     = {1'b0, winCnt} + (CNT_W+1)'(1);
    accept      = pktValid && (phase == S_WAIT || phase == S_WINDOW)
                  && !intervalEnd && !cfgLoad;
    stb.push    = accept && !fifoFull;
    stb.pop     = (phase == S_DRAIN) && !fifoEmpty && !intervalEnd && !cfgLoad;
    stb.decide  = (phase == S_DRAIN) && fifoEmpty && !intervalEnd && !cfgLoad;
    stb.clear   = intervalEnd || cfgLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgT         <= CNT_W'(DEF_T);
      cfgW         <= CNT_W'(DEF_W);
      intCnt       <= '0;
      winCnt       <= '0;
      phase        <= S_WAIT;
      destValid    <= 1'b0;
      noCandidate  <= 1'b0;
      fifoOverflow <= 1'b0;
    end else begin
      destValid    <= stb.decide;
      noCandidate  <= intervalEnd && !cfgLoad && (phase == S_WAIT);
      fifoOverflow <= accept && fifoFull;
      if (cfgLoad) begin
        cfgT   <= cfgInterval;
        cfgW   <= cfgWindow;
        intCnt <= '0;
        winCnt <= '0;
        phase  <= S_WAIT;
      end else if (intervalEnd) begin
        intCnt <= '0;
        winCnt <= '0;
        phase  <= S_WAIT;
      end else begin
        intCnt <= intCnt + CNT_W'(1);
        unique case (phase)
          S_WAIT: begin
            if (accept) begin
              winCnt <= CNT_W'(1);
              phase  <= (cfgW <= CNT_W'(1)) ? S_DRAIN : S_WINDOW;
            end
          end
          S_WINDOW: begin
            winCnt <= winNext[CNT_W-1:0];
            if (winNext >= {1'b0, cfgW}) phase <= S_DRAIN;
          end
          S_DRAIN: begin
            if (fifoEmpty) phase <= S_DONE;
          end
          S_DONE: begin
            phase <= S_DONE;
          end
          default: phase <= S_WAIT;
        endcase
      end
    end
  end

  // R5: the decision strobe lasts exactly one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    destValid |=> !destValid);

  // R6: an empty interval never coincides with a decision
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(destValid && noCandidate));

  // R9: a configuration load silences both strobes on the next cycle
  a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> (!destValid && !noCandidate));

endmodule

// File: rtl/dest_picker_dp.sv
module dest_picker_dp
  import dest_picker_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  report_t         pktReport,
  output logic            fifoFull,
  output logic            fifoEmpty,
  output logic [ID_W-1:0] destId
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int OCC_W = $clog2(FIFO_DEPTH + 1);

  report_t           slots [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [OCC_W-1:0]  occ;
  report_t           head;
  logic [COST_W-1:0] headCost;
  logic [COST_W-1:0] bestCost;
  logic [ID_W-1:0]   bestId;
  logic              bestValid;
  logic              take;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar g = 0; g < FIFO_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (stb.push && wrPtr == PTR_W'(g)) slots[g] <= pktReport;
    end
  end

  always_comb begin
    fifoFull  = (occ == OCC_W'(FIFO_DEPTH));
    fifoEmpty = (occ == '0);
    head      = slots[rdPtr];
    headCost  = report_cost(head);
    take      = !bestValid || (headCost < bestCost)
                || ((headCost == bestCost) && (head.id < bestId));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occ       <= '0;
      bestCost  <= '0;
      bestId    <= '0;
      bestValid <= 1'b0;
      destId    <= '0;
    end else begin
      if (stb.decide) destId <= bestId;
      if (stb.clear) begin
        wrPtr     <= '0;
        rdPtr     <= '0;
        occ       <= '0;
        bestValid <= 1'b0;
      end else begin
        if (stb.push) begin
          wrPtr <= ptr_next(wrPtr);
          occ   <= occ + OCC_W'(1);
        end else if (stb.pop) begin
          rdPtr <= ptr_next(rdPtr);
          occ   <= occ - OCC_W'(1);
          if (take) begin
            bestCost  <= headCost;
            bestId    <= head.id;
            bestValid <= 1'b1;
          end
        end
      end
    end
  end

  // R7: occupancy never exceeds the queue depth
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(FIFO_DEPTH));

  // R4: collection and draining never overlap
  a_r4_push_pop_split: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.push && stb.pop));

  // R2: the running best cost never rises while reports drain
  a_r2_best_monotone: assert property (@(posedge clk) disable iff (!rstN)
    (bestValid && !stb.clear) |=> (bestCost <= $past(bestCost)));

  // R5: a decision always has a candidate behind it
  a_r5_decide_has_best: assert property (@(posedge clk) disable iff (!rstN)
    stb.decide |-> bestValid);

  // R6: the destination moves only on a decision
  a_r6_hold_dest: assert property (@(posedge clk) disable iff (!rstN)
    !stb.decide |=> $stable(destId));

endmodule

// File: rtl/dest_picker.sv
module dest_picker
  import dest_picker_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int DEF_T      = 256,
  parameter int DEF_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] cfgInterval,
  input  logic [CNT_W-1:0] cfgWindow,
  input  logic             pktValid,
  input  logic [3:0]       pktId,
  input  logic [7:0]       pktUtil,
  input  logic [3:0]       pktHops,
  output logic             destValid,
  output logic [3:0]       destId,
  output logic             noCandidate,
  output logic             fifoOverflow
);

  strobe_t stb;
  report_t pktReport;
  logic    fifoFull;
  logic    fifoEmpty;

  assign pktReport = '{id: pktId, util: pktUtil, hops: pktHops};

  dest_picker_ctrl #(
    .CNT_W (CNT_W),
    .DEF_T (DEF_T),
    .DEF_W (DEF_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgLoad      (cfgLoad),
    .cfgInterval  (cfgInterval),
    .cfgWindow    (cfgWindow),
    .pktValid     (pktValid),
    .fifoFull     (fifoFull),
    .fifoEmpty    (fifoEmpty),
    .stb          (stb),
    .destValid    (destValid),
    .noCandidate  (noCandidate),
    .fifoOverflow (fifoOverflow)
  );

  dest_picker_dp #(
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .pktReport (pktReport),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .destId    (destId)
  );

endmodule

// File: tb/dest_picker_test.sv
`timescale 1ns/1ps
module dest_picker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [15:0] cfgInterval = '0;
  logic [15:0] cfgWindow = '0;
  logic        pktValid = 1'b0;
  logic [3:0]  pktId = '0;
  logic [7:0]  pktUtil = '0;
  logic [3:0]  pktHops = '0;
  logic        destValid;
  logic [3:0]  destId;
  logic        noCandidate;
  logic        fifoOverflow;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  int dvCnt = 0;
  int ncCnt = 0;
  int ovfCnt = 0;
  int bId [16];
  int bUtil [16];
  int bHop [16];
  int firstEdge;
  int lastDest = 0;
  bit finished = 0;

  dest_picker uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgInterval(cfgInterval),
    .cfgWindow(cfgWindow), .pktValid(pktValid), .pktId(pktId),
    .pktUtil(pktUtil), .pktHops(pktHops), .destValid(destValid),
    .destId(destId), .noCandidate(noCandidate), .fifoOverflow(fifoOverflow)
  );

  always #4 clk = ~clk;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  always @(negedge clk) begin
    if (destValid) dvCnt <= dvCnt + 1;
    if (noCandidate) ncCnt <= ncCnt + 1;
    if (fifoOverflow) ovfCnt <= ovfCnt + 1;
  end

  always @(posedge clk) begin
    if (edgeCnt > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual edge %0d expected below 20000", edgeCnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic loadCfg(int t, int w);
    cfgInterval = 16'(t);
    cfgWindow = 16'(w);
    cfgLoad = 1'b1;
    step();
    cfgLoad = 1'b0;
  endtask

  task automatic sendList(int k);
    for (int i = 0; i < k; i++) begin
      pktValid = 1'b1;
      pktId = 4'(bId[i]);
      pktUtil = 8'(bUtil[i]);
      pktHops = 4'(bHop[i]);
      step();
      if (i == 0) firstEdge = edgeCnt;
    end
    pktValid = 1'b0;
  endtask

  function automatic int bestOf(int k);
    int bi = bId[0];
    int bc = bUtil[0] * 4 + bHop[0];
    for (int i = 1; i < k; i++) begin
      int c = bUtil[i] * 4 + bHop[i];
      if (c < bc || (c == bc && bId[i] < bi)) begin
        bc = c;
        bi = bId[i];
      end
    end
    return bi;
  endfunction

  task automatic waitDecision(string req, int expId, int expEdge);
    for (int n = 0; n < 80; n++) begin
      if (destValid) begin
        check({req, " decision edge"}, edgeCnt == expEdge, edgeCnt, expEdge);
        check({req, " chosen id"}, int'(destId) == expId, int'(destId), expId);
        lastDest = int'(destId);
        return;
      end
      step();
    end
    check({req, " decision missing"}, 1'b0, 0, 1);
  endtask

  task automatic stepUntil(int e);
    while (edgeCnt < e) step();
  endtask

  initial begin
    int d0;
    int n0;
    int o0;
    int baseL;
    repeat (3) step();
    // R1: outputs quiet during reset
    check("R1 reset destValid", destValid == 1'b0, int'(destValid), 0);
    check("R1 reset flags", {noCandidate, fifoOverflow} == 2'b00,
          int'({noCandidate, fifoOverflow}), 0);
    rstN = 1'b1;
    step();
    check("R1 after reset destId", destId == 4'd0, int'(destId), 0);
    check("R1 after reset strobes", {destValid, noCandidate, fifoOverflow} == 3'b000,
          int'({destValid, noCandidate, fifoOverflow}), 0);

    // R2 R5: sweep of report patterns, counts and window lengths
    o0 = ovfCnt;
    for (int trial = 0; trial < 24; trial++) begin
      int k = 1 + trial % 8;
      int w = 5 + trial % 4;
      for (int i = 0; i < k; i++) begin
        bId[i] = (trial * 5 + i * 3) % 16;
        bUtil[i] = (trial * 7 + i * 13) % 6;
        bHop[i] = (trial * 3 + i * 5) % 16;
      end
      loadCfg(60, w);
      sendList(k);
      waitDecision("R2 R5 sweep", bestOf(k), firstEdge + w + k);
    end
    check("R7 no overflow with fitting bursts", ovfCnt == o0, ovfCnt - o0, 0);

    // R3: equal costs resolved by the lowest ID
    bId[0] = 9;  bUtil[0] = 2; bHop[0] = 4;
    bId[1] = 3;  bUtil[1] = 3; bHop[1] = 0;
    bId[2] = 12; bUtil[2] = 1; bHop[2] = 8;
    loadCfg(60, 6);
    sendList(3);
    waitDecision("R3 tie", 3, firstEdge + 6 + 3);

    // R4: a report after the window closes is ignored
    loadCfg(60, 4);
    bId[0] = 5; bUtil[0] = 40; bHop[0] = 2;
    bId[1] = 6; bUtil[1] = 30; bHop[1] = 9;
    sendList(1);
    step();
    bId[0] = 6; bUtil[0] = 30; bHop[0] = 9;
    pktValid = 1'b1; pktId = 4'd6; pktUtil = 8'd30; pktHops = 4'd9;
    step();
    pktValid = 1'b0;
    step();
    pktValid = 1'b1; pktId = 4'd1; pktUtil = 8'd0; pktHops = 4'd0;
    step();
    pktValid = 1'b0;
    waitDecision("R4 late report", 6, firstEdge + 4 + 2);

    // R7: overflow drops the reports beyond the depth
    for (int i = 0; i < 10; i++) begin
      bId[i] = i + 2;
      bUtil[i] = 20 - i;
      bHop[i] = i;
    end
    bId[8] = 0; bUtil[8] = 0; bHop[8] = 0;
    bId[9] = 1; bUtil[9] = 0; bHop[9] = 1;
    o0 = ovfCnt;
    loadCfg(60, 12);
    sendList(10);
    step();
    check("R7 overflow pulses", ovfCnt - o0 == 2, ovfCnt - o0, 2);
    waitDecision("R7 first reports kept", bestOf(8), firstEdge + 12 + 8);

    // R6: an empty interval keeps the destination
    d0 = dvCnt;
    loadCfg(40, 4);
    baseL = edgeCnt;
    stepUntil(baseL + 39);
    check("R6 no early flag", noCandidate == 1'b0, int'(noCandidate), 0);
    step();
    check("R6 flag at interval end", noCandidate == 1'b1, int'(noCandidate), 1);
    check("R6 destination kept", int'(destId) == lastDest, int'(destId), lastDest);
    step();
    check("R6 flag one cycle", noCandidate == 1'b0, int'(noCandidate), 0);
    check("R6 no decision", dvCnt == d0, dvCnt - d0, 0);

    // R8: one decision per interval, fresh window in the next
    loadCfg(60, 4);
    baseL = edgeCnt;
    bId[0] = 7; bUtil[0] = 10; bHop[0] = 3;
    sendList(1);
    waitDecision("R8 first decision", 7, baseL + 6);
    d0 = dvCnt;
    n0 = ncCnt;
    stepUntil(baseL + 19);
    bId[0] = 2; bUtil[0] = 0; bHop[0] = 0;
    sendList(1);
    stepUntil(baseL + 61);
    check("R8 no second decision", dvCnt == d0, dvCnt - d0, 0);
    check("R8 no empty flag after decision", ncCnt == n0, ncCnt - n0, 0);
    check("R8 destination unchanged", destId == 4'd7, int'(destId), 7);
    sendList(1);
    waitDecision("R8 next interval", 2, baseL + 62 + 4 + 1);

    // R9: a reload abandons an open window and applies the new length
    d0 = dvCnt;
    loadCfg(60, 8);
    bId[0] = 4; bUtil[0] = 1; bHop[0] = 1;
    bId[1] = 8; bUtil[1] = 1; bHop[1] = 0;
    sendList(2);
    loadCfg(60, 3);
    check("R9 reload quiet", {destValid, noCandidate} == 2'b00,
          int'({destValid, noCandidate}), 0);
    repeat (12) step();
    check("R9 abandoned window", dvCnt == d0, dvCnt - d0, 0);
    loadCfg(60, 3);
    bId[0] = 11; bUtil[0] = 5; bHop[0] = 5;
    sendList(1);
    waitDecision("R9 new window", 11, firstEdge + 3 + 1);
    loadCfg(20, 2);
    baseL = edgeCnt;
    n0 = ncCnt;
    stepUntil(baseL + 21);
    check("R9 new interval length", ncCnt - n0 == 1, ncCnt - n0, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule